// File: doc/BRIEF.md
# Banked Sector Decoder with Write Protection

This block sits between the address path and the embedded-operation controller of a 64 Mbit, four-bank flash array organised as 16-bit words. On an address-valid strobe it captures the bank and the erase-sector number that a 22-bit word address falls into. The sector number is decoded combinationally from the incoming address within the same cycle and then registered. Each bank covers 1 M words. The first and last banks each begin or end with a group of four 8-Kword boot sectors and fill the rest with 32-Kword sectors. The two inner banks contain only 32-Kword sectors. This gives 134 sectors, numbered upward from address zero.

From the captured sector and the present state of the protection inputs, the block raises a write-permit flag that the program/erase sequencer consults before it starts. Protection comes from three sources. The first is a per-sector software lock bitmap. The second is an acceleration-level input, which locks the whole array when low. The third is a write-protect pin, which pins down two boot sectors whatever their lock bits say. A parameter selects whether these are the two lowest or the two highest sectors.

The block also watches which bank is running an embedded program or erase. It flags a read whose captured bank is that busy bank, so the read path can return status instead of array data. Reads to any other bank are not flagged and go ahead at once.

Top module: `banked_sector_decoder`

## Requirements
- R1: `bank` equals bits 21..20 of the most recently captured address.
- R2: For a captured address below 32768, `sector` equals the address divided by 8192, giving sectors 0 to 3.
- R3: For a captured address from 32768 up to 4161535, `sector` equals (address − 32768) / 32768 + 4, giving sectors 4 to 129. Sector 34 is the last one in bank 0, 35 the first in bank 1, 67 the first in bank 2 and 99 the first in bank 3.
- R4: For a captured address of 4161536 or above, `sector` equals 130 + (address − 4161536) / 8192, giving sectors 130 to 133.
- R5: The address is captured on a rising clock edge where `addr_valid` is 1. On edges where it is 0, `bank` and `sector` keep their values even if `addr` changes.
- R6: After reset, `bank` is 0, `sector` is 0 and no read conflict is flagged while `busy` is 0.
- R7: When `acc_n` and `wp_n` are both 1, `write_ok` is 1 exactly when bit `sector` of `lock_map` is 0 (bit i of `lock_map` set means sector i is locked).
- R8: With the default bottom-boot setting (TOP_BOOT = 0), `wp_n` = 0 forces `write_ok` to 0 for sectors 0 and 1 even when their lock bits are clear. Other sectors are unaffected. With TOP_BOOT = 1 the pinned sectors are 132 and 133.
- R9: `acc_n` = 0 forces `write_ok` to 0 for every sector.
- R10: `read_conflict` is 1 exactly when `busy` is 1 and `bank` equals `busy_bank`. It is 0 for a captured address in any other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 22 | Word address |
| addr_valid | input | 1 | Capture strobe for `addr` |
| wp_n | input | 1 | Write-protect pin, active low |
| acc_n | input | 1 | Acceleration-level input; low locks all sectors |
| lock_map | input | 134 | Software lock bit per sector, 1 = locked |
| busy | input | 1 | An embedded program or erase is running |
| busy_bank | input | 2 | Bank that the running operation occupies |
| bank | output | 2 | Bank of the captured address |
| sector | output | 8 | Sector of the captured address |
| write_ok | output | 1 | Program or erase to the captured sector is permitted |
| read_conflict | output | 1 | Captured bank is the busy bank |

## Verification
The decoder is driven with addresses on both sides of every sector-size change and every bank edge. These include the first and last word of the bottom boot group, the first large sector, the last word of each bank and the first word of the next, and the two ends of the top boot group. Together they separate an off-by-one in the sector offsets from a wrong slot width. Randomly chosen addresses across the whole range then confirm the middle formula. A held strobe with a changing address separates capture from pass-through. Protection is tried with a single lock bit, then with the write-protect pin against both pinned and neighbouring sectors, and then with the acceleration lock. This shows whether each source blocks only what it should. A busy bank is walked across all four banks to show that conflicts are flagged only on a match.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  localparam int ADDR_W_DEF = 22;
  localparam int BANK_W_DEF = 2;
  localparam int MAIN_W_DEF = 15;
  localparam int BOOT_W_DEF = 13;
  localparam int WP_N_DEF   = 2;

  typedef enum logic [1:0] {
    DENY_NONE = 2'd0,
    DENY_ACC  = 2'd1,
    DENY_PIN  = 2'd2,
    DENY_SOFT = 2'd3
  } deny_e;
endpackage

// File: rtl/bsd_addr_decode.sv
module bsd_addr_decode #(
  parameter int ADDR_W = 22,
  parameter int BANK_W = 2,
  parameter int MAIN_W = 15,
  parameter int BOOT_W = 13,
  parameter int SECT_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank_d,
  output logic [SECT_W-1:0] sector_d
);
  localparam int SLOT_W   = ADDR_W - MAIN_W;
  localparam int SUB_W    = MAIN_W - BOOT_W;
  localparam int BOOT_N   = 1 << SUB_W;
  localparam int SLOTS    = 1 << SLOT_W;
  localparam int TOP_BASE = BOOT_N + SLOTS - 2;

  function automatic logic [SECT_W-1:0] sector_of(input logic [ADDR_W-1:0] a);
    logic [SLOT_W-1:0] slot;
    logic [SUB_W-1:0]  sub;
    slot = a[ADDR_W-1:MAIN_W];
    sub  = a[MAIN_W-1:BOOT_W];
    if (slot == '0)
      sector_of = SECT_W'(sub);
    else if (slot == '1)
      sector_of = SECT_W'(TOP_BASE) + SECT_W'(sub);
    else
      sector_of = SECT_W'(slot) + SECT_W'(BOOT_N - 1);
  endfunction

  function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] a);
    bank_of = a[ADDR_W-1 -: BANK_W];
  endfunction

  always_comb begin
    bank_d   = bank_of(addr);
    sector_d = sector_of(addr);
  end
endmodule

// File: rtl/bsd_protect.sv
module bsd_protect
  import bsd_pkg::*;
#(
  parameter int SECT_W   = 8,
  parameter int NUM_SECT = 134,
  parameter int WP_N     = 2,
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic [SECT_W-1:0]   sector,
  input  logic [NUM_SECT-1:0] lock_map,
  input  logic                wp_n,
  input  logic                acc_n,
  output logic                pin_sector,
  output deny_e               deny,
  output logic                write_ok
);
  generate
    if (TOP_BOOT) begin : g_top
      assign pin_sector = (sector >= SECT_W'(NUM_SECT - WP_N)) && (sector < SECT_W'(NUM_SECT));
    end else begin : g_bottom
      assign pin_sector = (sector < SECT_W'(WP_N));
    end
  endgenerate

  always_comb begin
    if (!acc_n)
      deny = DENY_ACC;
    else if (!wp_n && pin_sector)
      deny = DENY_PIN;
    else if (lock_map[sector])
      deny = DENY_SOFT;
    else
      deny = DENY_NONE;
    write_ok = (deny == DENY_NONE);
  end
endmodule

// File: rtl/bsd_bank_busy.sv
module bsd_bank_busy #(
  parameter int BANK_W = 2
) (
  input  logic [BANK_W-1:0] bank,
  input  logic              busy,
  input  logic [BANK_W-1:0] busy_bank,
  output logic              read_conflict
);
  always_comb read_conflict = busy && (bank == busy_bank);
endmodule

// File: rtl/banked_sector_decoder.sv
module banked_sector_decoder
  import bsd_pkg::*;
#(
  parameter int ADDR_W   = ADDR_W_DEF,
  parameter int BANK_W   = BANK_W_DEF,
  parameter int MAIN_W   = MAIN_W_DEF,
  parameter int BOOT_W   = BOOT_W_DEF,
  parameter int WP_N     = WP_N_DEF,
  parameter bit TOP_BOOT = 1'b0,
  parameter int NUM_SECT = 2 * (1 << (MAIN_W - BOOT_W)) + (1 << (ADDR_W - MAIN_W)) - 2,
  parameter int SECT_W   = $clog2(NUM_SECT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                addr_valid,
  input  logic                wp_n,
  input  logic                acc_n,
  input  logic [NUM_SECT-1:0] lock_map,
  input  logic                busy,
  input  logic [BANK_W-1:0]   busy_bank,
  output logic [BANK_W-1:0]   bank,
  output logic [SECT_W-1:0]   sector,
  output logic                write_ok,
  output logic                read_conflict
);
  logic [BANK_W-1:0] dec_bank;
  logic [SECT_W-1:0] dec_sector;
  logic              pin_sector;
  deny_e             deny;

  bsd_addr_decode #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .MAIN_W(MAIN_W),
    .BOOT_W(BOOT_W), .SECT_W(SECT_W)
  ) u_decode (
    .addr     (addr),
    .bank_d   (dec_bank),
    .sector_d (dec_sector)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank   <= '0;
      sector <= '0;
    end else if (addr_valid) begin
      bank   <= dec_bank;
      sector <= dec_sector;
    end
  end

  bsd_protect #(
    .SECT_W(SECT_W), .NUM_SECT(NUM_SECT), .WP_N(WP_N), .TOP_BOOT(TOP_BOOT)
  ) u_protect (
    .sector     (sector),
    .lock_map   (lock_map),
    .wp_n       (wp_n),
    .acc_n      (acc_n),
    .pin_sector (pin_sector),
    .deny       (deny),
    .write_ok   (write_ok)
  );

  bsd_bank_busy #(.BANK_W(BANK_W)) u_busy (
    .bank          (bank),
    .busy          (busy),
    .busy_bank     (busy_bank),
    .read_conflict (read_conflict)
  );
endmodule

// File: rtl/bsd_checker.sv
module bsd_checker
  import bsd_pkg::*;
#(
  parameter int BANK_W   = 2,
  parameter int SECT_W   = 8,
  parameter int NUM_SECT = 134,
  parameter int WP_N     = 2,
  parameter bit TOP_BOOT = 1'b0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                addr_valid,
  input logic                wp_n,
  input logic                acc_n,
  input logic [NUM_SECT-1:0] lock_map,
  input logic                busy,
  input logic [BANK_W-1:0]   busy_bank,
  input logic [BANK_W-1:0]   bank,
  input logic [SECT_W-1:0]   sector,
  input logic [SECT_W-1:0]   dec_sector,
  input logic                write_ok,
  input logic                read_conflict,
  input deny_e               deny
);
  logic pinned;
  assign pinned = TOP_BOOT ? (sector >= SECT_W'(NUM_SECT - WP_N)) : (sector < SECT_W'(WP_N));

  p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sector < SECT_W'(NUM_SECT));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |=> $stable(sector) && $stable(bank));

  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> sector == $past(dec_sector));

  p_soft_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_map[sector] |-> !write_ok);

  p_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_n && wp_n && !lock_map[sector]) |-> write_ok);

  p_pin_boot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && pinned) |-> !write_ok);

  p_acc_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_n |-> (!write_ok && deny == DENY_ACC));

  p_conflict_r10: assert property (@(posedge clk) disable iff (!rst_n)
    read_conflict |-> (busy && bank == busy_bank));

  p_no_conflict_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && bank != busy_bank) |-> !read_conflict);
endmodule

bind banked_sector_decoder bsd_checker #(
  .BANK_W(BANK_W), .SECT_W(SECT_W), .NUM_SECT(NUM_SECT),
  .WP_N(WP_N), .TOP_BOOT(TOP_BOOT)
) u_bsd_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .addr_valid    (addr_valid),
  .wp_n          (wp_n),
  .acc_n         (acc_n),
  .lock_map      (lock_map),
  .busy          (busy),
  .busy_bank     (busy_bank),
  .bank          (bank),
  .sector        (sector),
  .dec_sector    (dec_sector),
  .write_ok      (write_ok),
  .read_conflict (read_conflict),
  .deny          (deny)
);

// File: tb/test_banked_sector_decoder.sv
module test_banked_sector_decoder;
  localparam int TOP_BOOT_START = 4194304 - 32768;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [21:0]  addr = '0;
  logic         addr_valid = 1'b0;
  logic         wp_n = 1'b1;
  logic         acc_n = 1'b1;
  logic [133:0] lock_map = '0;
  logic         busy = 1'b0;
  logic [1:0]   busy_bank = '0;
  logic [1:0]   bank;
  logic [7:0]   sector;
  logic         write_ok;
  logic         read_conflict;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  banked_sector_decoder i_banked_sector_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .addr_valid(addr_valid),
    .wp_n(wp_n), .acc_n(acc_n), .lock_map(lock_map), .busy(busy),
    .busy_bank(busy_bank), .bank(bank), .sector(sector),
    .write_ok(write_ok), .read_conflict(read_conflict)
  );

  function automatic int ref_sector(input int a);
    if (a < 32768) return a / 8192;
    if (a >= TOP_BOOT_START) return 130 + (a - TOP_BOOT_START) / 8192;
    return (a - 32768) / 32768 + 4;
  endfunction

  function automatic string region_req(input int a);
    if (a < 32768) return "R2";
    if (a >= TOP_BOOT_START) return "R4";
    return "R3";
  endfunction

  // behavioural reference: the last captured address
  int m_addr = 0;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) m_addr <= 0;
    else if (addr_valid) m_addr <= int'(addr);

  task automatic check_eq(input string req, input string what, input int got, input int exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // every-cycle comparison against the model
  always begin
    @(negedge clk);
    #3;
    if (rst_n && !done) begin
      int es;
      bit ew, ec;
      string wreq;
      es = ref_sector(m_addr);
      ew = acc_n && !(!wp_n && es < 2) && !lock_map[es];
      ec = busy && (busy_bank == 2'(m_addr / 1048576));
      wreq = !acc_n ? "R9" : (!wp_n && es < 2) ? "R8" : "R7";
      check_eq("R1", "bank", int'(bank), m_addr / 1048576);
      check_eq(region_req(m_addr), "sector", int'(sector), es);
      check_eq(wreq, "write_ok", int'(write_ok), int'(ew));
      check_eq("R10", "read_conflict", int'(read_conflict), int'(ec));
    end
  end

  task automatic load(input int a);
    @(negedge clk);
    addr = 22'(a);
    addr_valid = 1'b1;
    @(negedge clk);
    addr_valid = 1'b0;
  endtask

  initial begin
    int addrs [16] = '{0, 8191, 8192, 16384, 24576, 32767, 32768, 65535,
                       1048575, 1048576, 2097152, 3145728, 4161535, 4161536,
                       4186112, 4194303};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #4;
    // R6: reset state
    check_eq("R6", "bank after reset", int'(bank), 0);
    check_eq("R6", "sector after reset", int'(sector), 0);
    check_eq("R6", "read_conflict after reset", int'(read_conflict), 0);

    // R2 R3 R4: boundary walk
    foreach (addrs[i]) load(addrs[i]);
    load(1048575); #4 check_eq("R3", "last sector of bank 0", int'(sector), 34);
    load(1048576); #4 check_eq("R3", "first sector of bank 1", int'(sector), 35);
    load(4194303); #4 check_eq("R4", "top sector", int'(sector), 133);
    for (int i = 0; i < 40; i++) load(int'($urandom_range(4194303, 0)));

    // R5: strobe low holds the captured address
    load(2097152 + 5 * 32768);
    @(negedge clk); addr = 22'(8192);
    @(negedge clk); addr = 22'(4194303);
    #4 check_eq("R5", "sector held without strobe", int'(sector), 72);
    check_eq("R5", "bank held without strobe", int'(bank), 2);

    // R7: software lock on one sector
    lock_map[4] = 1'b1;
    load(32768); #4 check_eq("R7", "locked sector 4", int'(write_ok), 0);
    load(65536); #4 check_eq("R7", "neighbour sector 5 open", int'(write_ok), 1);
    lock_map = '0;

    // R8: write-protect pin on boot sectors
    wp_n = 1'b0;
    load(0);      #4 check_eq("R8", "pin blocks sector 0", int'(write_ok), 0);
    load(8192);   #4 check_eq("R8", "pin blocks sector 1", int'(write_ok), 0);
    load(16384);  #4 check_eq("R8", "sector 2 unaffected", int'(write_ok), 1);
    load(4177920);#4 check_eq("R8", "sector 132 unaffected", int'(write_ok), 1);
    wp_n = 1'b1;
    #1 check_eq("R8", "sector 132 after pin release", int'(write_ok), 1);

    // R9: acceleration lock blocks everything
    acc_n = 1'b0;
    load(1048576); #4 check_eq("R9", "acc lock sector 35", int'(write_ok), 0);
    load(4194303); #4 check_eq("R9", "acc lock sector 133", int'(write_ok), 0);
    acc_n = 1'b1;

    // R10: busy bank walk
    busy = 1'b1;
    for (int b = 0; b < 4; b++) begin
      busy_bank = 2'(b);
      for (int t = 0; t < 4; t++) begin
        load(t * 1048576 + 40000);
        #4 check_eq("R10", "conflict flag", int'(read_conflict), int'(t == b));
      end
    end
    busy = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule